// File: doc/BRIEF.md
# Registered Six-Bit Lookup with Shared Bidirectional Port

This block turns one 6-bit code into another through a fixed 64-entry table, using a single 6-bit bidirectional pin group for both directions. While the external agent owns the port (`ext_drive` high), the block samples the port into an address register on every rising clock edge. When the agent lets go of the port and lowers `ext_drive`, the block returns the table entry for the stored address on the same pins through tri-state drivers.

The table is set at elaboration time and cannot be reloaded at run time. It is described one output bit at a time. Each of the six output bits has its own 64-bit parameter word, and bit `a` of that word is the output bit for address `a`. The default words give a compressive curve close to `a^0.95` over the 0 to 63 range.

A host uses the block like this: raise `ext_drive`, drive a code for at least one clock, release the pins to high impedance, lower `ext_drive`, then read the result. The result stays valid as long as `ext_drive` stays low.

Top module: `lut6_port`

## Requirements
- R1: A synchronous active-high `rst` clears the address register to 0. With `rst` high the block drives no port bit. The first lookup after reset with no new load returns the entry for address 0.
- R2: With `ext_drive` = 1 and `rst` low, the address register takes the port value at every rising clock edge.
- R3: With `ext_drive` = 0, the address register keeps its value, so the returned entry does not change across any number of cycles.
- R4: With `ext_drive` = 0 and `rst` low, the block drives all six port bits with the table entry for the stored address. The lookup is combinational, so the value is on the port in the same cycle that `ext_drive` falls.
- R5: Port bit k, for k = 0 to 5, equals bit `a` of the k-th column parameter word, where `a` is the stored address and bit 0 is the least significant bit of the word. Column 5 is the most significant word in the packed table parameter.
- R6: With `ext_drive` = 1 the block leaves every port bit undriven, so the port carries exactly the value the external agent drives.
- R7: With the default table, address 0 returns 0, address 32 returns 27 and address 63 returns 52.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_drive | input | 1 | 1: external agent drives the port and the code is loaded; 0: block drives the result |
| data_io | inout | 6 | Shared code input and table output |

## Verification
Each of the 64 codes is driven in turn and then read back. Because every address reaches every column word, this sweep separates errors in bit order, address order and column order.

Longer hold periods with `ext_drive` low show whether the register keeps its value or drifts. Back-to-back loads with no gap show that every edge samples the port.

Loading a nonzero code and then resetting shows whether reset truly clears the register, as opposed to the address-0 entry only happening to match. A final check of three fixed addresses against known constants ties the default table to its intended curve, independently of the parameter words.

// File: rtl/lut6_pkg.sv
package lut6_pkg;

    localparam int CODE_W = 6;
    localparam int DEPTH  = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [DEPTH-1:0]  column_t;

    // Default column words, output bit 5 first (most significant in the packed array).
    localparam logic [CODE_W-1:0][DEPTH-1:0] POW095_COLS = {
        64'hffffffc000000000,
        64'hfc00003ffffc0000,
        64'h03ff003ff003ff00,
        64'h83e0f83e0f83e0f0,
        64'h639ce739ce7398cc,
        64'h5a5296b5ad6a56aa
    };

    typedef enum logic [0:0] {
        PORT_LOAD   = 1'b1,
        PORT_RETURN = 1'b0
    } port_dir_e;

endpackage

// File: rtl/lut6_addr_reg.sv
module lut6_addr_reg #(
    parameter int W = lut6_pkg::CODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    // R1
    addr_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));

    // R2
    addr_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

endmodule

// File: rtl/lut6_column.sv
module lut6_column #(
    parameter int               W     = lut6_pkg::CODE_W,
    parameter int               DEPTH = 1 << W,
    parameter logic [DEPTH-1:0] WORD  = '0
) (
    input  logic [W-1:0] addr,
    output logic         bit_out
);

    always_comb bit_out = WORD[addr];

endmodule

// File: rtl/lut6_bank.sv
module lut6_bank #(
    parameter int                     W     = lut6_pkg::CODE_W,
    parameter int                     DEPTH = 1 << W,
    parameter logic [W-1:0][DEPTH-1:0] COLS = lut6_pkg::POW095_COLS
) (
    input  logic [W-1:0] addr,
    output logic [W-1:0] value
);

    for (genvar k = 0; k < W; k++) begin : g_col
        lut6_column #(
            .W     (W),
            .DEPTH (DEPTH),
            .WORD  (COLS[k])
        ) u_col (
            .addr    (addr),
            .bit_out (value[k])
        );
    end

endmodule

// File: rtl/lut6_drive_ctl.sv
module lut6_drive_ctl (
    input  logic rst,
    input  logic ext_drive,
    output logic load,
    output logic drive_on
);

    import lut6_pkg::*;

    port_dir_e dir;

    always_comb begin
        dir      = port_dir_e'(ext_drive);
        load     = (dir == PORT_LOAD);
        drive_on = !rst && (dir == PORT_RETURN);
    end

endmodule

// File: rtl/lut6_port.sv
module lut6_port #(
    parameter int                      W     = lut6_pkg::CODE_W,
    parameter logic [W-1:0][(1<<W)-1:0] COLS = lut6_pkg::POW095_COLS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ext_drive,
    inout  wire  [W-1:0] data_io
);

    localparam int DEPTH = 1 << W;

    logic [W-1:0] addr_q;
    logic [W-1:0] lut_val;
    logic         load;
    logic         drive_on;

    lut6_drive_ctl u_ctl (
        .rst       (rst),
        .ext_drive (ext_drive),
        .load      (load),
        .drive_on  (drive_on)
    );

    lut6_addr_reg #(.W(W)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (data_io),
        .q    (addr_q)
    );

    lut6_bank #(.W(W), .DEPTH(DEPTH), .COLS(COLS)) u_bank (
        .addr  (addr_q),
        .value (lut_val)
    );

    assign data_io = drive_on ? lut_val : {W{1'bz}};

    // R4
    port_return_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_drive |-> (data_io == lut_val));

    // R6
    port_release_chk: assert property (@(posedge clk)
        (ext_drive || rst) |-> !drive_on);

endmodule

// File: tb/lut6_port_test.sv
module lut6_port_test;

    localparam logic [5:0][63:0] COLS = {
        64'hffffffc000000000, 64'hfc00003ffffc0000, 64'h03ff003ff003ff00,
        64'h83e0f83e0f83e0f0, 64'h639ce739ce7398cc, 64'h5a5296b5ad6a56aa
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_drive = 1'b0;
    logic       drv_en = 1'b0;
    logic [5:0] drv_val = '0;
    wire  [5:0] data_io;

    int n_cmp = 0;
    int n_bad = 0;
    int model_addr = 0;
    bit done = 1'b0;

    assign data_io = drv_en ? drv_val : 6'bz;

    lut6_port uut (
        .clk       (clk),
        .rst       (rst),
        .ext_drive (ext_drive),
        .data_io   (data_io)
    );

    always #10 clk = ~clk;

    // Behavioural model of the stored address.
    always @(posedge clk) begin
        if (rst)            model_addr <= 0;
        else if (ext_drive) model_addr <= int'(drv_val);
    end

    function automatic int ref_lookup(input int a);
        int r = 0;
        for (int k = 0; k < 6; k++) if (COLS[k][a]) r += (1 << k);
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: change inputs after the falling edge, then compare.
    task automatic step(input bit rs, input bit oe, input int v, input string req);
        @(negedge clk);
        rst = rs; ext_drive = oe; drv_en = oe; drv_val = 6'(v);
        #1;
        if (!rs) begin
            if (oe) check({req, "/R6"}, int'(data_io), v);
            else    check(req, int'(data_io), ref_lookup(model_addr));
        end
    endtask

    initial begin
        repeat (3) step(1'b1, 1'b0, 0, "R1");
        // R1: reset state returns address-0 entry
        step(1'b0, 1'b0, 0, "R1");
        // R2/R4/R5: full sweep, lookup valid in the cycle ext_drive falls
        for (int a = 0; a < 64; a++) begin
            step(1'b0, 1'b1, a, "R2");
            step(1'b0, 1'b0, 0, "R4_R5");
        end
        // R3: hold over many cycles
        step(1'b0, 1'b1, 45, "R2");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 0, "R3");
        // R2: back-to-back loads, only last one counts
        for (int a = 10; a < 20; a++) step(1'b0, 1'b1, a, "R2");
        step(1'b0, 1'b0, 0, "R2");
        // R1: reset clears a nonzero address
        step(1'b0, 1'b1, 63, "R2");
        step(1'b1, 1'b0, 0, "R1");
        step(1'b0, 1'b0, 0, "R1");
        check("R1", int'(data_io), 0);
        // R7: fixed points of the default curve
        step(1'b0, 1'b1, 32, "R7");
        step(1'b0, 1'b0, 0, "R7");
        check("R7", int'(data_io), 27);
        step(1'b0, 1'b1, 63, "R7");
        step(1'b0, 1'b0, 0, "R7");
        check("R7", int'(data_io), 52);
        step(1'b0, 1'b1, 0, "R7");
        step(1'b0, 1'b0, 0, "R7");
        check("R7", int'(data_io), 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule